// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block collapses and restores one switchable power domain through a fixed, timed order of steps. It drives two groups of power-switch enables (a small group that brings the rail up gently and a larger group that completes it), the domain clock enable, the domain reset, the IO isolation clamp and a pair of retention controls for memories and peripherals. Software controls it through one 32-bit control/status word: a write sets the request, the mode bits and the three wait fields, and a read returns them together with a power-good status flag.

A request is a level: the domain is asked to be off while the selected request is 1, and on while it is 0. The request comes from the software collapse bit, or from the `hw_req_off` pin when hardware-trigger mode is set. After it sees a new request, the sequencer spends a start-up latency before the first visible step. The status flag changes only when a whole sequence has finished. An override mode hands the switch, clamp, reset and clock outputs straight to register bits and freezes the state machine.

States: `PS_ON`, `PS_LAUNCH_OFF`, `PS_UNRETAIN`, `PS_CLK_OFF`, `PS_SW_OFF`, `PS_OFF`, `PS_LAUNCH_ON`, `PS_UNCLAMP`, `PS_FEW_ON`, `PS_REST_ON`, `PS_RETAIN`. Transitions: `PS_ON`→`PS_LAUNCH_OFF` on an off request; `PS_LAUNCH_OFF`→`PS_UNRETAIN`→`PS_CLK_OFF`→`PS_SW_OFF`→`PS_OFF` as each dwell expires; `PS_OFF`→`PS_LAUNCH_ON` when the request drops; `PS_LAUNCH_ON`→`PS_UNCLAMP`→`PS_FEW_ON`→`PS_REST_ON`→`PS_RETAIN`→`PS_ON` as each dwell expires. While override is set, no transition is taken.

Top module: `pd_gate_seq`

## Requirements
- R1: After reset the domain is on: both switch groups, clock enable and both retention outputs are 1, clamp and domain reset are 0, and a read returns 0x8000_0000.
- R2: Control word fields: bit 0 software off request, bit 1 hardware-trigger mode, bit 2 override, bits 4..8 override values for few switches, rest switches, clamp, domain reset and clock enable, bits 15:12 clock-off wait, bits 19:16 few-switch wait, bits 23:20 rest-switch wait, bit 31 read-only status; other bits read 0.
- R3: Status (bit 31) becomes 1 in the cycle the domain reaches on, becomes 0 in the cycle it reaches off, and holds its old value for the whole of a sequence.
- R4: Power-down order: the first step comes STARTUP_CYC+1 (9) cycles after the write edge that sets the off request; retention clears for 1 cycle, then the clock is off for the clock-off wait, then both switch groups are off for 1 cycle, then clamp and domain reset assert.
- R5: Power-up order: the first step comes 9 cycles after the request-clearing write edge; the clamp releases for 1 cycle, the few group turns on for the few wait, then the rest group turns on for the rest wait, then retention sets and domain reset releases, and the clock enables HOLDOFF_CYC (40) cycles later.
- R6: A wait field value n sets a dwell of 2^n clock cycles, so zero fields give 1-cycle dwells.
- R7: In hardware-trigger mode the request follows `hw_req_off` and the software bit has no effect; the pin is sampled by the state machine directly, so the first step comes STARTUP_CYC (8) cycles after the edge that samples a change.
- R8: A request that changes during a sequence does not alter that sequence; once it ends in on or off, the current request level is acted on.
- R9: With override set, the switch, clamp, reset and clock outputs follow bits 4..8 from the cycle after the write, retention and status keep their values, and the state machine does not advance.
- R10: Memory and peripheral retention outputs are set only while both switch groups are on, and always change together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Control word readback with status in bit 31 |
| hw_req_off | input | 1 | Hardware off request, used in hardware-trigger mode |
| sw_few_en | output | 1 | Enable for the small power-switch group |
| sw_rest_en | output | 1 | Enable for the remaining power-switch group |
| dom_clk_en | output | 1 | Domain clock enable |
| dom_reset | output | 1 | Domain reset, active high |
| io_clamp | output | 1 | IO isolation clamp, active high |
| ret_mem | output | 1 | Memory retention control |
| ret_periph | output | 1 | Peripheral retention control |

## Verification
The hardest situation to reach is a request that flips while a sequence is still running, since it must be timed against dwells that the wait fields stretch. The stimulus programs long waits, launches a power-down, and clears the request again a dozen cycles later, while the clock-off dwell is still running; the scoreboard then expects the whole power-down to finish and a power-up to start exactly nine cycles after the off state is reached. Freezing under override is reached the same way: the off request is set under override and held for longer than the start-up latency, so any movement of the state machine would show up once override is released.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

    localparam int WAIT_W = 4;

    localparam int BIT_REQ_OFF   = 0;
    localparam int BIT_HWTRIG    = 1;
    localparam int BIT_OVR       = 2;
    localparam int BIT_OVR_FEW   = 4;
    localparam int BIT_OVR_REST  = 5;
    localparam int BIT_OVR_CLAMP = 6;
    localparam int BIT_OVR_RST   = 7;
    localparam int BIT_OVR_CLK   = 8;
    localparam int LSB_CLK_WAIT  = 12;
    localparam int LSB_FEW_WAIT  = 16;
    localparam int LSB_REST_WAIT = 20;
    localparam int BIT_STATUS    = 31;

    typedef enum logic [3:0] {
        PS_ON,
        PS_LAUNCH_OFF,
        PS_UNRETAIN,
        PS_CLK_OFF,
        PS_SW_OFF,
        PS_OFF,
        PS_LAUNCH_ON,
        PS_UNCLAMP,
        PS_FEW_ON,
        PS_REST_ON,
        PS_RETAIN
    } pdg_state_e;

    typedef struct packed {
        logic few;
        logic rest;
        logic clk;
        logic rst;
        logic clamp;
    } pdg_switch_t;

endpackage

// File: rtl/pdg_ctrl_regs.sv
module pdg_ctrl_regs
    import pdg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              status_i,
    input  logic              hw_req_off_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              req_off_o,
    output logic              ovr_en_o,
    output pdg_switch_t       ovr_drive_o,
    output logic [WAIT_W-1:0] clk_wait_o,
    output logic [WAIT_W-1:0] few_wait_o,
    output logic [WAIT_W-1:0] rest_wait_o
);

    function automatic logic [DATA_W-1:0] writable_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        m[BIT_REQ_OFF]   = 1'b1;
        m[BIT_HWTRIG]    = 1'b1;
        m[BIT_OVR]       = 1'b1;
        m[BIT_OVR_FEW]   = 1'b1;
        m[BIT_OVR_REST]  = 1'b1;
        m[BIT_OVR_CLAMP] = 1'b1;
        m[BIT_OVR_RST]   = 1'b1;
        m[BIT_OVR_CLK]   = 1'b1;
        for (int i = 0; i < WAIT_W; i++) begin
            m[LSB_CLK_WAIT + i]  = 1'b1;
            m[LSB_FEW_WAIT + i]  = 1'b1;
            m[LSB_REST_WAIT + i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] WR_MASK = writable_bits();

    logic [DATA_W-1:0] ctrl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else if (wr_en_i) begin
            ctrl_q <= wdata_i & WR_MASK;
        end
    end

    always_comb begin
        rdata_o             = ctrl_q;
        rdata_o[BIT_STATUS] = status_i;
    end

    assign req_off_o   = ctrl_q[BIT_HWTRIG] ? hw_req_off_i : ctrl_q[BIT_REQ_OFF];
    assign ovr_en_o    = ctrl_q[BIT_OVR];
    assign clk_wait_o  = ctrl_q[LSB_CLK_WAIT +: WAIT_W];
    assign few_wait_o  = ctrl_q[LSB_FEW_WAIT +: WAIT_W];
    assign rest_wait_o = ctrl_q[LSB_REST_WAIT +: WAIT_W];

    always_comb begin
        ovr_drive_o.few   = ctrl_q[BIT_OVR_FEW];
        ovr_drive_o.rest  = ctrl_q[BIT_OVR_REST];
        ovr_drive_o.clamp = ctrl_q[BIT_OVR_CLAMP];
        ovr_drive_o.rst   = ctrl_q[BIT_OVR_RST];
        ovr_drive_o.clk   = ctrl_q[BIT_OVR_CLK];
    end

endmodule

// File: rtl/pdg_dwell_timer.sv
module pdg_dwell_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pdg_step_fsm.sv
module pdg_step_fsm
    import pdg_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int STARTUP_CYC = 8,
    parameter int HOLDOFF_CYC = 40
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_off_i,
    input  logic              freeze_i,
    input  logic [WAIT_W-1:0] clk_wait_i,
    input  logic [WAIT_W-1:0] few_wait_i,
    input  logic [WAIT_W-1:0] rest_wait_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              restart_o,
    output pdg_switch_t       drive_o,
    output logic              ret_o,
    output logic              status_o
);

    localparam logic [CNT_W-1:0] ONE_CYC     = CNT_W'(1);
    localparam logic [CNT_W-1:0] STARTUP_LEN = CNT_W'(STARTUP_CYC);
    localparam logic [CNT_W-1:0] HOLDOFF_LEN = CNT_W'(HOLDOFF_CYC);

    pdg_state_e       state_q, state_d;
    logic [CNT_W-1:0] dwell;
    logic             step_done;
    logic             status_q;

    // dwell length of the current state, in cycles
    always_comb begin
        unique case (state_q)
            PS_LAUNCH_OFF, PS_LAUNCH_ON: dwell = STARTUP_LEN;
            PS_CLK_OFF:                  dwell = ONE_CYC << clk_wait_i;
            PS_FEW_ON:                   dwell = ONE_CYC << few_wait_i;
            PS_REST_ON:                  dwell = ONE_CYC << rest_wait_i;
            PS_RETAIN:                   dwell = HOLDOFF_LEN;
            default:                     dwell = ONE_CYC;
        endcase
    end

    assign step_done = (cnt_i >= (dwell - ONE_CYC));

    always_comb begin
        state_d = state_q;
        if (!freeze_i) begin
            unique case (state_q)
                PS_ON:         if (req_off_i) state_d = PS_LAUNCH_OFF;
                PS_LAUNCH_OFF: if (step_done) state_d = PS_UNRETAIN;
                PS_UNRETAIN:   if (step_done) state_d = PS_CLK_OFF;
                PS_CLK_OFF:    if (step_done) state_d = PS_SW_OFF;
                PS_SW_OFF:     if (step_done) state_d = PS_OFF;
                PS_OFF:        if (!req_off_i) state_d = PS_LAUNCH_ON;
                PS_LAUNCH_ON:  if (step_done) state_d = PS_UNCLAMP;
                PS_UNCLAMP:    if (step_done) state_d = PS_FEW_ON;
                PS_FEW_ON:     if (step_done) state_d = PS_REST_ON;
                PS_REST_ON:    if (step_done) state_d = PS_RETAIN;
                PS_RETAIN:     if (step_done) state_d = PS_ON;
                default:       state_d = PS_ON;
            endcase
        end
    end

    assign restart_o = (state_d != state_q);

    // state register and power-good flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q  <= PS_ON;
            status_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_d == PS_ON) begin
                status_q <= 1'b1;
            end else if (state_d == PS_OFF) begin
                status_q <= 1'b0;
            end
        end
    end

    assign status_o = status_q;

    // output decode
    always_comb begin
        drive_o = '0;
        ret_o   = 1'b0;
        unique case (state_q)
            PS_ON, PS_LAUNCH_OFF: begin
                drive_o.few  = 1'b1;
                drive_o.rest = 1'b1;
                drive_o.clk  = 1'b1;
                ret_o        = 1'b1;
            end
            PS_UNRETAIN: begin
                drive_o.few  = 1'b1;
                drive_o.rest = 1'b1;
                drive_o.clk  = 1'b1;
            end
            PS_CLK_OFF: begin
                drive_o.few  = 1'b1;
                drive_o.rest = 1'b1;
            end
            PS_SW_OFF: begin
                drive_o = '0;
            end
            PS_OFF, PS_LAUNCH_ON: begin
                drive_o.clamp = 1'b1;
                drive_o.rst   = 1'b1;
            end
            PS_UNCLAMP: begin
                drive_o.rst = 1'b1;
            end
            PS_FEW_ON: begin
                drive_o.few = 1'b1;
                drive_o.rst = 1'b1;
            end
            PS_REST_ON: begin
                drive_o.few  = 1'b1;
                drive_o.rest = 1'b1;
                drive_o.rst  = 1'b1;
            end
            PS_RETAIN: begin
                drive_o.few  = 1'b1;
                drive_o.rest = 1'b1;
                ret_o        = 1'b1;
            end
            default: begin
                drive_o = '0;
                ret_o   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pd_gate_seq.sv
module pd_gate_seq
    import pdg_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int STARTUP_CYC = 8,
    parameter int HOLDOFF_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              hw_req_off,
    output logic              sw_few_en,
    output logic              sw_rest_en,
    output logic              dom_clk_en,
    output logic              dom_reset,
    output logic              io_clamp,
    output logic              ret_mem,
    output logic              ret_periph
);

    localparam int CNT_W = 2 ** WAIT_W;

    logic              req_off;
    logic              ovr_en;
    pdg_switch_t       ovr_drive;
    pdg_switch_t       fsm_drive;
    pdg_switch_t       out_drive;
    logic [WAIT_W-1:0] clk_wait, few_wait, rest_wait;
    logic [CNT_W-1:0]  dwell_cnt;
    logic              restart;
    logic              fsm_ret;
    logic              status;

    pdg_ctrl_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (cfg_wr_en),
        .wdata_i      (cfg_wdata),
        .status_i     (status),
        .hw_req_off_i (hw_req_off),
        .rdata_o      (cfg_rdata),
        .req_off_o    (req_off),
        .ovr_en_o     (ovr_en),
        .ovr_drive_o  (ovr_drive),
        .clk_wait_o   (clk_wait),
        .few_wait_o   (few_wait),
        .rest_wait_o  (rest_wait)
    );

    pdg_dwell_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .restart_i (restart),
        .cnt_o     (dwell_cnt)
    );

    pdg_step_fsm #(
        .CNT_W       (CNT_W),
        .STARTUP_CYC (STARTUP_CYC),
        .HOLDOFF_CYC (HOLDOFF_CYC)
    ) u_fsm (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_off_i   (req_off),
        .freeze_i    (ovr_en),
        .clk_wait_i  (clk_wait),
        .few_wait_i  (few_wait),
        .rest_wait_i (rest_wait),
        .cnt_i       (dwell_cnt),
        .restart_o   (restart),
        .drive_o     (fsm_drive),
        .ret_o       (fsm_ret),
        .status_o    (status)
    );

    assign out_drive  = ovr_en ? ovr_drive : fsm_drive;

    assign sw_few_en  = out_drive.few;
    assign sw_rest_en = out_drive.rest;
    assign dom_clk_en = out_drive.clk;
    assign dom_reset  = out_drive.rst;
    assign io_clamp   = out_drive.clamp;
    assign ret_mem    = fsm_ret;
    assign ret_periph = fsm_ret;

endmodule

// File: rtl/pd_gate_seq_chk.sv
module pd_gate_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_rdata,
    input logic        sw_few_en,
    input logic        sw_rest_en,
    input logic        dom_clk_en,
    input logic        dom_reset,
    input logic        io_clamp,
    input logic        ret_mem,
    input logic        ret_periph
);

    logic ovr;
    logic stat;
    assign ovr  = cfg_rdata[2];
    assign stat = cfg_rdata[31];

    // R5: rest group never on without the few group outside override
    a_r5_rest_needs_few: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && sw_rest_en) |-> sw_few_en);

    // R5: clock only runs with clamp and reset released
    a_r5_clk_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && dom_clk_en) |-> (!io_clamp && !dom_reset));

    // R10: retention only with full power
    a_r10_ret_powered: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && (ret_mem || ret_periph)) |-> (sw_few_en && sw_rest_en));

    // R4: clamp asserts only once switches are off
    a_r4_clamp_after_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && $rose(io_clamp)) |-> (!sw_few_en && !sw_rest_en));

    // R3: status rises only with the clock running
    a_r3_status_rise_on: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && $rose(stat)) |-> dom_clk_en);

    // R3: status falls only with clamp and reset asserted
    a_r3_status_fall_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && $fell(stat)) |-> (io_clamp && dom_reset));

endmodule

bind pd_gate_seq pd_gate_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rdata  (cfg_rdata),
    .sw_few_en  (sw_few_en),
    .sw_rest_en (sw_rest_en),
    .dom_clk_en (dom_clk_en),
    .dom_reset  (dom_reset),
    .io_clamp   (io_clamp),
    .ret_mem    (ret_mem),
    .ret_periph (ret_periph)
);

// File: tb/pd_gate_seq_tb.sv
module pd_gate_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        hw_req_off = 1'b0;
    logic        sw_few_en, sw_rest_en, dom_clk_en, dom_reset, io_clamp, ret_mem, ret_periph;

    always #5 clk = ~clk;

    pd_gate_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .hw_req_off (hw_req_off),
        .sw_few_en  (sw_few_en),
        .sw_rest_en (sw_rest_en),
        .dom_clk_en (dom_clk_en),
        .dom_reset  (dom_reset),
        .io_clamp   (io_clamp),
        .ret_mem    (ret_mem),
        .ret_periph (ret_periph)
    );

    // vector: {few, rest, clk, rst, clamp, ret_mem, ret_periph, status}
    localparam logic [7:0] V_ON      = 8'b1110_0111;
    localparam logic [7:0] V_UNRET   = 8'b1110_0001;
    localparam logic [7:0] V_CLKOFF  = 8'b1100_0001;
    localparam logic [7:0] V_SWOFF   = 8'b0000_0001;
    localparam logic [7:0] V_OFF     = 8'b0001_1000;
    localparam logic [7:0] V_UNCLAMP = 8'b0001_0000;
    localparam logic [7:0] V_FEW     = 8'b1001_0000;
    localparam logic [7:0] V_REST    = 8'b1101_0000;
    localparam logic [7:0] V_RET     = 8'b1100_0110;
    localparam int         HOLDOFF   = 40;

    typedef struct {
        logic [7:0] vec;
        int         delta;
        string      req;
    } sb_item_t;

    sb_item_t   sb_q[$];
    int         cyc = 0;
    int         last_chg = 0;
    logic [7:0] last_vec;
    bit         mon_en = 1'b0;
    int         n_chk = 0;
    int         n_fail = 0;

    function automatic logic [7:0] out_vec();
        return {sw_few_en, sw_rest_en, dom_clk_en, dom_reset, io_clamp,
                ret_mem, ret_periph, cfg_rdata[31]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare each output change with the next expected item
    always @(negedge clk) begin
        if (mon_en) begin
            logic [7:0] cur;
            cur = out_vec();
            if (cur !== last_vec) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected output change", cur, last_vec);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    check(cur === it.vec, it.req, "output vector", cur, it.vec);
                    check((cyc - last_chg) == it.delta, it.req, "cycles to step",
                          cyc - last_chg, it.delta);
                end
                last_chg = cyc;
                last_vec = cur;
            end
        end
    end

    task automatic push(input logic [7:0] v, input int d, input string r);
        sb_item_t it;
        it.vec = v; it.delta = d; it.req = r;
        sb_q.push_back(it);
    endtask

    task automatic push_down(input int cw, input int first);
        push(V_UNRET,  first,    "R4");
        push(V_CLKOFF, 1,        "R4");
        push(V_SWOFF,  1 << cw,  "R6");
        push(V_OFF,    1,        "R3");
    endtask

    task automatic push_up(input int fw, input int rw, input int first);
        push(V_UNCLAMP, first,   "R5");
        push(V_FEW,     1,       "R5");
        push(V_REST,    1 << fw, "R6");
        push(V_RET,     1 << rw, "R6");
        push(V_ON,      HOLDOFF, "R5");
    endtask

    task automatic write_reg(input logic [31:0] d, input bit mark);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wdata = d;
        @(posedge clk);
        #1;
        if (mark) last_chg = cyc;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(out_vec() === V_ON, "R1", "reset outputs", out_vec(), V_ON);
        check(cfg_rdata === 32'h8000_0000, "R1", "reset readback", cfg_rdata, 32'h8000_0000);
        last_vec = out_vec();
        mon_en   = 1'b1;

        // R4/R6: power-down with 1-cycle waits
        push_down(0, 9);
        write_reg(32'h0000_0001, 1'b1);
        drain();
        check(cfg_rdata === 32'h0000_0001, "R3", "status after off", cfg_rdata, 32'h0000_0001);

        // R5: power-up with 1-cycle waits
        push_up(0, 0, 9);
        write_reg(32'h0000_0000, 1'b1);
        drain();
        check(cfg_rdata === 32'h8000_0000, "R3", "status after on", cfg_rdata, 32'h8000_0000);

        // R6/R2: programmed waits clk=3 few=2 rest=4
        push_down(3, 9);
        write_reg(32'h0042_3001, 1'b1);
        drain();
        check(cfg_rdata === 32'h0042_3001, "R2", "field readback", cfg_rdata, 32'h0042_3001);
        push_up(2, 4, 9);
        write_reg(32'h0042_3000, 1'b1);
        drain();

        // R2: unused bits read back as zero
        write_reg(32'h0F00_0E08 | 32'h0042_3000, 1'b0);
        check(cfg_rdata === 32'h8042_3000, "R2", "reserved bits", cfg_rdata, 32'h8042_3000);

        // R8: request cleared in the middle of a power-down
        push_down(3, 9);
        push_up(2, 4, 9);
        write_reg(32'h0042_3001, 1'b1);
        repeat (10) @(negedge clk);
        write_reg(32'h0042_3000, 1'b0);
        drain();
        check(cfg_rdata[31] === 1'b1, "R8", "back on after held request", cfg_rdata[31], 1);

        // R7: hardware-trigger mode ignores the software bit
        write_reg(32'h0042_3003, 1'b1);
        repeat (30) @(negedge clk);
        check(out_vec() === V_ON, "R7", "software bit ignored", out_vec(), V_ON);
        push_down(3, 8);
        @(negedge clk);
        hw_req_off = 1'b1;
        @(posedge clk);
        #1;
        last_chg = cyc;
        drain();
        check(cfg_rdata[31] === 1'b0, "R7", "off by pin", cfg_rdata[31], 0);
        push_up(2, 4, 8);
        @(negedge clk);
        hw_req_off = 1'b0;
        @(posedge clk);
        #1;
        last_chg = cyc;
        drain();
        check(cfg_rdata[31] === 1'b1, "R7", "on by pin", cfg_rdata[31], 1);

        // R9: override drives outputs and freezes the sequencer
        push(8'b0101_1111, 0, "R9");
        write_reg(32'h0042_30E5, 1'b1);
        repeat (40) @(negedge clk);
        check(cfg_rdata[31] === 1'b1, "R9", "status kept under override", cfg_rdata[31], 1);
        push(V_ON, 0, "R9");
        write_reg(32'h0042_3000, 1'b1);
        drain();
        repeat (30) @(negedge clk);
        check(out_vec() === V_ON, "R9", "no movement after release", out_vec(), V_ON);
        check(ret_mem === ret_periph, "R10", "retention pair", ret_periph, ret_mem);
        check(sb_q.size() == 0, "R9", "scoreboard empty", sb_q.size(), 0);

        finish_run();
    end

endmodule